// File: doc/BRIEF.md
# Transposed-Form FIR Filter Chain

This block is a five-tap finite impulse response filter built as a chain of identical multiply-add cells. Each new input sample goes to every cell at once. Each cell multiplies the sample by its own fixed weight and adds the product to the partial sum passed down from the cell before it. The cell that holds weight h0 closes the chain and drives the filtered output. With all cells in feedthrough, the filter takes one sample and gives one result on every clock.

A single mode input controls every cell's output stage. When it is set, each cell adds one register stage to its output. The lag between neighbouring taps then becomes two cycles. Two sample streams interleaved on alternate cycles can then share one set of weights, and each stream's results come out on its own cycle parity. A build-time mask can also hold a chosen cell's output stage in registered form in both modes. This inserts one zero-weight lag into the response. Weights are loaded through a small write port that selects one tap by index. They are meant to stay unchanged while samples stream.

Top module: `tfir_chain`

## Requirements
- R1: A write with `coef_we` high and `coef_idx` = k, for k below NTAPS, stores `coef_data` as signed weight h_k at that clock edge. The cell holding h0 is the last in the chain, and the cell holding h(NTAPS-1) is the first.
- R2: A write with `coef_idx` at NTAPS or above changes no weight.
- R3: Let x_e(n) be the sample the filter holds after cycle n. Let e_k be 1 when cell k inserts its output register and 0 otherwise. In single mode (`mode_dual` = 0), e_k = `HOLD_MASK[k]`. Then y(t) = sum over k of h_k * x_e(t - D_k), with D_k = 2 + e_k + sum over m<k of (1 + e_m), and a sample earlier than reset counts as 0.
- R4: In dual mode (`mode_dual` = 1), every e_k is 1. This gives D_k = 3 + 2k, so the taps are spaced two cycles apart and even and odd cycles form two independent streams.
- R5: A set bit k in `HOLD_MASK` adds one cycle of lag ahead of tap k. In single mode this puts a zero-weight lag into the impulse response.
- R6: While `in_valid` is low, the held sample does not change (x_e(n) = x_e(n-1)), whatever value `x_in` carries.
- R7: `y_valid` equals `in_valid` delayed by 2 cycles, or by 3 cycles when `mode_dual` = 1 or `HOLD_MASK[0]` is set.
- R8: Reset clears every weight, sample, product and partial sum. During reset and in the first cycle after it, `y_out` is 0 and `y_valid` is low.
- R9: `y_out` is a two's complement value SW bits wide. Each product is sign-extended to SW bits before it is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_dual | input | 1 | 1 = two interleaved streams (extra register per tap); 0 = single stream |
| coef_we | input | 1 | Weight write strobe |
| coef_idx | input | IW (3) | Index k of the weight h_k to write |
| coef_data | input | HW (12) | Signed weight value |
| in_valid | input | 1 | Sample strobe; loads `x_in` into every cell |
| x_in | input | XW (12) | Signed input sample |
| y_out | output | SW (26) | Signed filter output |
| y_valid | output | 1 | Marks the output cycle of each accepted sample |

## Verification
Each tap's contribution reaches `y_out` a fixed number of cycles after its sample is taken: two cycles for h0 in single mode, three in dual mode, and one or two cycles more for each tap further up the chain, plus one for each masked cell. The bench keeps the accepted-sample history as an integer array indexed by cycle. After every falling edge it rebuilds y(t) from the lag formula of R3 and R4 and checks it against `y_out`. It also checks `y_valid` against `in_valid` delayed by 2 or 3 cycles. Impulse tests add explicit checks at each tap's exact lag, including the zero lag that the masked cell inserts.

// File: rtl/tfir_pkg.sv
package tfir_pkg;

   // Number of stages a valid strobe needs to cover the longest output lag.
   localparam int unsigned VLD_STAGES = 3;

   // The last cell adds one output stage when dual mode is on or its hold bit is set.
   function automatic logic last_stage_extra(input logic dual, input logic hold_last);
      return dual | hold_last;
   endfunction

endpackage

// File: rtl/tfir_cell.sv
module tfir_cell #(
   parameter int unsigned XW         = 12,
   parameter int unsigned HW         = 12,
   parameter int unsigned SW         = 26,
   parameter bit          FORCE_HOLD = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_load,
   input  logic [XW-1:0] a_in,
   input  logic          b_load,
   input  logic [HW-1:0] b_in,
   input  logic [SW-1:0] c_in,
   input  logic          feed,
   output logic [XW-1:0] a_q,
   output logic [HW-1:0] b_q,
   output logic [SW-1:0] s_out
);
   localparam int unsigned PW = XW + HW;

   logic signed [XW-1:0] a_r;
   logic signed [HW-1:0] b_r;
   logic signed [PW-1:0] p_r;
   logic signed [SW-1:0] c_r;
   logic signed [SW-1:0] s_r;
   logic signed [SW-1:0] p_ext;
   logic signed [SW-1:0] sum;

   // sample and weight registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_r <= '0;
         b_r <= '0;
      end else begin
         if (a_load) a_r <= a_in;
         if (b_load) b_r <= b_in;
      end
   end

   // product, incoming partial sum and outgoing sum registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_r <= '0;
         c_r <= '0;
         s_r <= '0;
      end else begin
         p_r <= a_r * b_r;
         c_r <= c_in;
         s_r <= sum;
      end
   end

   always_comb begin
      p_ext = SW'(p_r);
      sum   = c_r + p_ext;
   end

   generate
      if (FORCE_HOLD) begin : g_hold
         assign s_out = s_r;
      end else begin : g_mux
         assign s_out = feed ? sum : s_r;
      end
   endgenerate

   assign a_q = a_r;
   assign b_q = b_r;

endmodule

// File: rtl/tfir_vpipe.sv
module tfir_vpipe #(
   parameter int unsigned DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d,
   output logic [DEPTH-1:0] taps
);
   logic [DEPTH-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q[0] <= d;
   end

   generate
      for (genvar i = 1; i < DEPTH; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= q[i-1];
         end
      end
   endgenerate

   assign taps = q;

endmodule

// File: rtl/tfir_chain.sv
module tfir_chain #(
   parameter int unsigned     NTAPS     = 5,
   parameter int unsigned     XW        = 12,
   parameter int unsigned     HW        = 12,
   parameter int unsigned     SW        = 26,
   parameter logic [NTAPS-1:0] HOLD_MASK = '0,
   localparam int unsigned    IW        = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_dual,
   input  logic          coef_we,
   input  logic [IW-1:0] coef_idx,
   input  logic [HW-1:0] coef_data,
   input  logic          in_valid,
   input  logic [XW-1:0] x_in,
   output logic [SW-1:0] y_out,
   output logic          y_valid
);
   import tfir_pkg::*;

   generate
      if (NTAPS < 1) begin : g_bad_taps
         $error("tfir_chain: NTAPS must be at least 1");
      end
      if (SW < XW + HW) begin : g_bad_sw
         $error("tfir_chain: SW must hold a full product");
      end
   endgenerate

   logic [SW-1:0]       s_vec [NTAPS];
   logic [NTAPS*XW-1:0] a_flat;
   logic [NTAPS*HW-1:0] coef_flat;
   logic [VLD_STAGES-1:0] vtaps;
   logic                feed;

   assign feed = ~mode_dual;

   // one cell per weight; weight index k, h(NTAPS-1) heads the chain
   generate
      for (genvar k = 0; k < NTAPS; k++) begin : g_tap
         logic          wr;
         logic [SW-1:0] c_src;

         assign wr = coef_we && (coef_idx == IW'(k));

         if (k == NTAPS - 1) begin : g_head
            assign c_src = '0;
         end else begin : g_link
            assign c_src = s_vec[k+1];
         end

         tfir_cell #(
            .XW        (XW),
            .HW        (HW),
            .SW        (SW),
            .FORCE_HOLD(HOLD_MASK[k])
         ) cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .a_load(in_valid),
            .a_in  (x_in),
            .b_load(wr),
            .b_in  (coef_data),
            .c_in  (c_src),
            .feed  (feed),
            .a_q   (a_flat[k*XW +: XW]),
            .b_q   (coef_flat[k*HW +: HW]),
            .s_out (s_vec[k])
         );
      end
   endgenerate

   tfir_vpipe #(.DEPTH(VLD_STAGES)) vpipe_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (in_valid),
      .taps (vtaps)
   );

   assign y_out   = s_vec[0];
   assign y_valid = last_stage_extra(mode_dual, HOLD_MASK[0]) ? vtaps[2] : vtaps[1];

endmodule

// File: rtl/tfir_chain_chk.sv
module tfir_chain_chk #(
   parameter int unsigned NTAPS = 5,
   parameter int unsigned XW    = 12,
   parameter int unsigned HW    = 12,
   parameter int unsigned SW    = 26,
   parameter int unsigned IW    = 3,
   parameter bit          HOLD0 = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mode_dual,
   input logic                coef_we,
   input logic [IW-1:0]       coef_idx,
   input logic [HW-1:0]       coef_data,
   input logic                in_valid,
   input logic [SW-1:0]       y_out,
   input logic                y_valid,
   input logic [NTAPS*XW-1:0] a_flat,
   input logic [NTAPS*HW-1:0] coef_flat
);
   logic [1:0] since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          since <= '0;
      else if (since != 3) since <= since + 2'd1;
   end

   // R8
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since == 2'd0) |-> (y_out == '0 && !y_valid));

   // R1
   coef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since != 2'd0 && $past(coef_we) && int'($past(coef_idx)) < NTAPS)
      |-> coef_flat[int'($past(coef_idx))*HW +: HW] == $past(coef_data));

   // R2
   coef_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since != 2'd0 && $past(coef_we) && int'($past(coef_idx)) >= NTAPS)
      |-> $stable(coef_flat));

   // R6
   sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since != 2'd0 && !$past(in_valid)) |-> $stable(a_flat));

   // R7
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since == 2'd3 && !HOLD0 && !mode_dual && !$past(mode_dual) && !$past(mode_dual, 2))
      |-> y_valid == $past(in_valid, 2));

   // R7
   valid_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since == 2'd3 && mode_dual && $past(mode_dual) && $past(mode_dual, 2) && $past(mode_dual, 3))
      |-> y_valid == $past(in_valid, 3));

endmodule

bind tfir_chain tfir_chain_chk #(
   .NTAPS(NTAPS),
   .XW   (XW),
   .HW   (HW),
   .SW   (SW),
   .IW   (IW),
   .HOLD0(HOLD_MASK[0])
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_dual(mode_dual),
   .coef_we  (coef_we),
   .coef_idx (coef_idx),
   .coef_data(coef_data),
   .in_valid (in_valid),
   .y_out    (y_out),
   .y_valid  (y_valid),
   .a_flat   (a_flat),
   .coef_flat(coef_flat)
);

// File: tb/tfir_chain_tb_top.sv
`timescale 1ns/1ps
module tfir_chain_tb_top;
   localparam int unsigned NTAPS = 5;
   localparam int unsigned XW    = 12;
   localparam int unsigned HW    = 12;
   localparam int unsigned SW    = 26;
   localparam int unsigned IW    = 3;
   localparam logic [NTAPS-1:0] HOLD = 5'b00100;
   localparam int MAXC = 2048;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_dual = 1'b0;
   logic          coef_we = 1'b0;
   logic [IW-1:0] coef_idx = '0;
   logic [HW-1:0] coef_data = '0;
   logic          in_valid = 1'b0;
   logic [XW-1:0] x_in = '0;
   logic [SW-1:0] y_out;
   logic          y_valid;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   int  t = 0;
   bit  dual_m = 1'b0;
   longint xe [MAXC];
   bit     vh [MAXC];
   longint hm [NTAPS];
   string  tag = "R3";

   always #2 clk = ~clk;

   tfir_chain #(
      .NTAPS(NTAPS), .XW(XW), .HW(HW), .SW(SW), .HOLD_MASK(HOLD)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_dual(mode_dual),
      .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
      .in_valid(in_valid), .x_in(x_in), .y_out(y_out), .y_valid(y_valid)
   );

   function automatic int lag(input int k);
      int d = 2;
      int e;
      e = (dual_m || HOLD[k]) ? 1 : 0;
      d += e;
      for (int m = 0; m < k; m++) d += 1 + ((dual_m || HOLD[m]) ? 1 : 0);
      return d;
   endfunction

   function automatic longint xat(input int i);
      return (i < 0) ? 0 : xe[i];
   endfunction

   function automatic logic [SW-1:0] model_y(input int tc);
      longint acc = 0;
      for (int k = 0; k < NTAPS; k++) acc += hm[k] * xat(tc - lag(k));
      return SW'(acc);
   endfunction

   function automatic bit model_v(input int tc);
      int l = (dual_m || HOLD[0]) ? 3 : 2;
      return (tc - l < 0) ? 1'b0 : vh[tc - l];
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", req, t, act, exp);
      end
   endtask

   task automatic compare_now();
      logic [SW-1:0] ey = model_y(t);
      check(y_out == ey, tag, longint'($signed(y_out)), longint'($signed(ey)));
      check(y_valid == model_v(t), "R7", longint'(y_valid), longint'(model_v(t)));
   endtask

   // Apply inputs for cycle t, then move to the next falling edge and compare.
   task automatic step(input bit v, input logic [XW-1:0] x,
                       input bit we = 1'b0, input int idx = 0, input int dat = 0);
      in_valid  = v;
      x_in      = x;
      coef_we   = we;
      coef_idx  = IW'(idx);
      coef_data = HW'(dat);
      xe[t] = v ? longint'($signed(x)) : xat(t - 1);
      vh[t] = v;
      if (we && idx < NTAPS) hm[idx] = longint'($signed(HW'(dat)));
      @(negedge clk);
      t++;
      compare_now();
   endtask

   task automatic do_reset(input bit dual);
      rst_n = 1'b0;
      in_valid = 1'b0; coef_we = 1'b0; x_in = '0;
      mode_dual = dual;
      dual_m = dual;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t = 0;
      for (int i = 0; i < MAXC; i++) begin xe[i] = 0; vh[i] = 1'b0; end
      for (int k = 0; k < NTAPS; k++) hm[k] = 0;
      // R8: reset state
      check(y_out == '0, "R8", longint'(y_out), 0);
      check(y_valid == 1'b0, "R8", longint'(y_valid), 0);
   endtask

   task automatic load_weights(input int w0, input int w1, input int w2, input int w3, input int w4);
      tag = "R1 R2";
      step(0, 12'h5A5, 1, 0, w0);
      step(0, '0, 1, 5, 999);        // R2: out-of-range index
      step(0, '0, 1, 1, w1);
      step(0, '0, 1, 2, w2);
      step(0, '0, 1, 7, -1234);      // R2: out-of-range index
      step(0, '0, 1, 3, w3);
      step(0, '0, 1, 4, w4);
      step(0, '0, 1, 6, 77);         // R2: out-of-range index
   endtask

   task automatic flush(input int n);
      for (int i = 0; i < n; i++) step(1, '0);
   endtask

   task automatic final_report();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         final_report();
         $finish;
      end
   end

   initial begin
      int t0;
      // ---------------- single-stream mode ----------------
      do_reset(1'b0);
      load_weights(3, -5, 7, 11, -2);
      flush(4);
      tag = "R1 R2 R3 R5";
      t0 = t;
      step(1, 12'd1);
      flush(10);
      // explicit impulse lags: 2,3,(4 = zero lag from mask),5,6,7
      begin
         logic [SW-1:0] ir [12];
         for (int i = 0; i < 12; i++) ir[i] = model_y(t0 + i);
         check(ir[2] == SW'(3),  "R1", longint'($signed(ir[2])), 3);
         check(ir[3] == SW'(-5), "R3", longint'($signed(ir[3])), -5);
         check(ir[4] == SW'(0),  "R5", longint'($signed(ir[4])), 0);
         check(ir[5] == SW'(7),  "R5", longint'($signed(ir[5])), 7);
         check(ir[7] == SW'(-2), "R2", longint'($signed(ir[7])), -2);
      end
      tag = "R3 R9";
      for (int i = 0; i < 80; i++) step(1, XW'($urandom));
      tag = "R6";
      for (int i = 0; i < 60; i++) step(($urandom % 3) != 0, XW'($urandom));
      tag = "R9";
      for (int i = 0; i < 20; i++) step(1, (i % 2) ? 12'h800 : 12'h7FF);
      flush(12);
      // R1: rewrite one weight after a flush, then an impulse
      tag = "R1";
      step(0, '0, 1, 3, -2048);
      flush(2);
      step(1, 12'd1);
      flush(10);
      tag = "R3";
      for (int i = 0; i < 30; i++) step(1, XW'($urandom));

      // ---------------- interleaved mode ----------------
      do_reset(1'b1);
      load_weights(-9, 4, 13, -6, 8);
      flush(4);
      tag = "R4";
      t0 = t;
      step(1, 12'd1);
      flush(14);
      begin
         logic [SW-1:0] ir [14];
         for (int i = 0; i < 14; i++) ir[i] = model_y(t0 + i);
         check(ir[3]  == SW'(-9), "R4", longint'($signed(ir[3])), -9);
         check(ir[4]  == SW'(0),  "R4", longint'($signed(ir[4])), 0);
         check(ir[5]  == SW'(4),  "R4", longint'($signed(ir[5])), 4);
         check(ir[11] == SW'(8),  "R4", longint'($signed(ir[11])), 8);
      end
      // two streams on even and odd cycles
      for (int i = 0; i < 100; i++)
         step(1, (i % 2) ? XW'($urandom % 64) : XW'(-($urandom % 512)));
      tag = "R4 R6";
      for (int i = 0; i < 40; i++) step(($urandom % 4) != 0, XW'($urandom));
      flush(14);

      done = 1'b1;
      final_report();
      $finish;
   end

endmodule